// File: doc/BRIEF.md
# Truncated Timestamp Seconds Expander

A frame timestamp written back by a DMA engine keeps the full nanoseconds but only a narrow slice of the seconds count. The slice is split across two descriptor words. This block takes those two words and the live seconds value of the free-running time-of-day counter. It rebuilds the full seconds value and passes it on together with the nanoseconds.

The live counter may have moved on since the frame was stamped, and its low seconds bits may have wrapped past the width of the slice in that time. The block detects this from the top bit of the slice. If that bit is set in the slice but clear in the live count, the rebuilt value is moved back by one slice period (2^TW seconds). The scheme assumes the capture is less than half a slice period older than the live count.

Both sides of the block are valid/ready streams. An input beat is accepted when `in_valid` and `in_ready` are both high. `live_sec` is sampled in the same cycle. A single output register holds the result. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output is held unchanged and no new beat is taken. A beat whose timestamp-valid flag is low is consumed and produces no output.

Top module: `tse_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The truncated seconds field (TW=6 bits) is formed as `{in_word1[3:0], in_word0[31:30]}`. `in_word1[31:4]` has no effect on the result. `out_nsec` equals `in_word0[29:0]` of the accepted beat.
- R3: When the top field bit (bit 5) of the truncated seconds is clear, or bit 5 of `live_sec` is set, `out_sec` equals `live_sec` with its low 6 bits replaced by the truncated field.
- R4: When bit 5 of the truncated field is set and bit 5 of `live_sec` is clear, `out_sec` equals `live_sec` with its low 6 bits replaced by the field, minus 64.
- R5: An accepted beat with `in_ts_ok` low is consumed and produces no output beat.
- R6: A result appears on the output (`out_valid` high) in the cycle right after its input beat is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_sec`/`out_nsec` stay unchanged. `in_ready` is 1 whenever `out_valid` is 0.
- R8: With `out_ready` held high, beats presented on consecutive cycles are all accepted and produce results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_word0 | input | 32 | First descriptor timestamp word (nanoseconds and low seconds bits) |
| in_word1 | input | 32 | Second descriptor timestamp word (high seconds bits of the field) |
| in_ts_ok | input | 1 | Descriptor timestamp-valid flag |
| live_sec | input | SEC_W (48) | Current seconds of the free-running clock |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_sec | output | SEC_W (48) | Rebuilt full seconds |
| out_nsec | output | NS_W (30) | Nanoseconds of the timestamp |

## Verification
The bench targets the wrap boundary from both sides:
- A field with its top bit set against a live count whose bit 5 is clear must come out 64 s lower. A design that skipped the correction would report a time up to a minute in the future.
- A field with its top bit clear, or a live count with bit 5 set, must not be moved. A design that compared the wrong bit, or subtracted in these cases, would report a time a minute in the past.
- All-ones and near-zero live counts show that the upper seconds bits carry through the subtraction. A design that only masked bits would show broken upper bits here.
- Junk in the unused high bits of the second word shows the field positions are right.

The other cases cover stream behaviour:
- A stalled output must hold its value and refuse new beats. A design that overwrote it would lose timestamps.
- A beat with the flag clear must vanish without an output.
- Back-to-back beats must each come out one cycle later, which a design that dropped ready after every beat would fail.

// File: rtl/tse_pkg.sv
package tse_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] desc_word_t;
endpackage

// File: rtl/tse_field_unpack.sv
module tse_field_unpack
  import tse_pkg::*;
#(
  parameter int unsigned NS_W = 30,
  parameter int unsigned TW   = 6,
  parameter int unsigned LO_W = 2
) (
  input  desc_word_t       w0,
  input  desc_word_t       w1,
  output logic [TW-1:0]    trunc_sec,
  output logic [NS_W-1:0]  nsec
);
  localparam int unsigned HI_W = TW - LO_W;

  assign nsec = w0[NS_W-1:0];

  generate
    if (HI_W > 0) begin : g_split
      assign trunc_sec = {w1[HI_W-1:0], w0[NS_W +: LO_W]};
      logic unused_w1_hi;
      assign unused_w1_hi = ^w1[WORD_W-1:HI_W];
    end else begin : g_single
      assign trunc_sec = w0[NS_W +: LO_W];
      logic unused_w1_all;
      assign unused_w1_all = ^w1;
    end
  endgenerate

  if (NS_W + LO_W < WORD_W) begin : g_w0_spare
    logic unused_w0_hi;
    assign unused_w0_hi = ^w0[WORD_W-1:NS_W+LO_W];
  end
endmodule

// File: rtl/tse_sec_merge.sv
module tse_sec_merge #(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned TW    = 6
) (
  input  logic [TW-1:0]    trunc_sec,
  input  logic [SEC_W-1:0] live_sec,
  output logic [SEC_W-1:0] full_sec
);
  // One slice period, 2^TW seconds.
  localparam logic [SEC_W-1:0] PERIOD = {{(SEC_W-TW-1){1'b0}}, 1'b1, {TW{1'b0}}};

  logic             wrapped;
  logic [SEC_W-1:0] base;

  // Slice top bit set while the live bit is clear: the live count wrapped after capture.
  assign wrapped  = trunc_sec[TW-1] & ~live_sec[TW-1];
  assign base     = {live_sec[SEC_W-1:TW], trunc_sec};
  assign full_sec = wrapped ? (base - PERIOD) : base;

  generate
    if (TW > 1) begin : g_low_spare
      logic unused_live_lo;
      assign unused_live_lo = ^live_sec[TW-2:0];
    end
  endgenerate
endmodule

// File: rtl/tse_out_stage.sv
module tse_out_stage #(
  parameter int unsigned DW = 78
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_keep,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic load;

  assign in_ready = ~out_valid | out_ready;
  assign load     = in_valid & in_ready & in_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tse_expander.sv
module tse_expander
  import tse_pkg::*;
#(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 30,
  parameter int unsigned TW    = 6,
  parameter int unsigned LO_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word0,
  input  logic [31:0]      in_word1,
  input  logic             in_ts_ok,
  input  logic [SEC_W-1:0] live_sec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SEC_W-1:0] out_sec,
  output logic [NS_W-1:0]  out_nsec
);
  localparam int unsigned DW = SEC_W + NS_W;

  logic [TW-1:0]    trunc_sec;
  logic [NS_W-1:0]  nsec;
  logic [SEC_W-1:0] full_sec;
  logic [DW-1:0]    res_q;

  tse_field_unpack #(.NS_W(NS_W), .TW(TW), .LO_W(LO_W)) unpack_i (
    .w0(desc_word_t'(in_word0)), .w1(desc_word_t'(in_word1)),
    .trunc_sec(trunc_sec), .nsec(nsec)
  );

  tse_sec_merge #(.SEC_W(SEC_W), .TW(TW)) merge_i (
    .trunc_sec(trunc_sec), .live_sec(live_sec), .full_sec(full_sec)
  );

  tse_out_stage #(.DW(DW)) stage_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_keep(in_ts_ok), .in_ready(in_ready),
    .in_data({full_sec, nsec}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign out_sec  = res_q[DW-1:NS_W];
  assign out_nsec = res_q[NS_W-1:0];
endmodule

// File: rtl/tse_expander_chk.sv
module tse_expander_chk #(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 30,
  parameter int unsigned TW    = 6,
  parameter int unsigned LO_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      in_word0,
  input logic [31:0]      in_word1,
  input logic             in_ts_ok,
  input logic [SEC_W-1:0] live_sec,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SEC_W-1:0] out_sec,
  input logic [NS_W-1:0]  out_nsec
);
  localparam int unsigned HI_W = TW - LO_W;

  logic acc_ok, acc_bad, wrap_in;
  logic [TW-1:0] field_in;
  assign acc_ok   = in_valid & in_ready & in_ts_ok;
  assign acc_bad  = in_valid & in_ready & ~in_ts_ok;
  assign field_in = {in_word1[HI_W-1:0], in_word0[NS_W +: LO_W]};
  assign wrap_in  = field_in[TW-1] & ~live_sec[TW-1];

  // R6
  a_r6_rise_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_ok));
  // R5
  a_r5_flag_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> !out_valid);
  // R7
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sec) && $stable(out_nsec)));
  // R7
  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R2
  a_r2_nsec_passes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> (out_valid && out_nsec == $past(in_word0[NS_W-1:0])));
  // R2
  a_r2_low_sec_field: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> (out_sec[TW-1:0] == $past(field_in)));
  // R4
  a_r4_wrap_steps_back: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && wrap_in) |=> (out_sec[SEC_W-1:TW] == $past(live_sec[SEC_W-1:TW]) - 1'b1));
  // R3
  a_r3_no_wrap_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !wrap_in) |=> (out_sec[SEC_W-1:TW] == $past(live_sec[SEC_W-1:TW])));
endmodule

bind tse_expander tse_expander_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .TW(TW), .LO_W(LO_W)) chk_i (.*);

// File: tb/tse_expander_tb.sv
module tse_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam int NV    = 8;

  localparam logic [47:0] V_LIVE [NV] = '{
    48'h0000_1000_0005, 48'h0000_1000_0041, 48'h0000_1000_0021, 48'h0000_1000_0020,
    48'h0000_ABCD_EF80, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9A3F, 48'h0000_0000_0040};
  localparam logic [5:0] V_TRUNC [NV] = '{
    6'h03, 6'h3E, 6'h3F, 6'h1F, 6'h20, 6'h00, 6'h3F, 6'h30};
  localparam logic [29:0] V_NSEC [NV] = '{
    30'd0, 30'd999_999_999, 30'd1, 30'd500_000_000,
    30'd123_456_789, 30'h3FFF_FFFF, 30'd42, 30'd777};
  localparam logic [47:0] V_EXP [NV] = '{
    48'h0000_1000_0003, 48'h0000_1000_003E, 48'h0000_1000_003F, 48'h0000_1000_001F,
    48'h0000_ABCD_EF60, 48'hFFFF_FFFF_FFC0, 48'h1234_5678_9A3F, 48'h0000_0000_0030};
  localparam string V_REQ [NV] = '{"R3", "R4", "R3", "R3", "R4", "R3", "R3", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ts_ok = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word0 = '0, in_word1 = '0;
  logic [SEC_W-1:0] live_sec = '0;
  logic in_ready, out_valid;
  logic [SEC_W-1:0] out_sec;
  logic [NS_W-1:0] out_nsec;
  int checks = 0, failures = 0;
  logic [47:0] held_sec;

  always #(CLK_PERIOD/2) clk = ~clk;

  tse_expander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word0(in_word0), .in_word1(in_word1), .in_ts_ok(in_ts_ok), .live_sec(live_sec),
    .out_valid(out_valid), .out_ready(out_ready), .out_sec(out_sec), .out_nsec(out_nsec));

  task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic present(input int i, input logic ok);
    in_word0 = {V_TRUNC[i][1:0], V_NSEC[i]};
    in_word1 = {28'hABCDEF0 ^ 28'(i * 28'h1111), V_TRUNC[i][5:2]};
    live_sec = V_LIVE[i];
    in_ts_ok = ok;
    in_valid = 1'b1;
  endtask

  task automatic check_vec(input int i);
    check_eq("R6", "out_valid", 64'(out_valid), 64'd1);
    check_eq(V_REQ[i], "out_sec", 64'(out_sec), 64'(V_EXP[i]));
    check_eq("R2", "out_nsec", 64'(out_nsec), 64'(V_NSEC[i]));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: state during and just after reset
    repeat (3) @(negedge clk);
    check_eq("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check_eq("R1", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check_eq("R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // Table walk: R2, R3, R4, R6
    for (int i = 0; i < NV; i++) begin
      present(i, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(i);
      @(negedge clk);
      check_eq("R6", "out_valid drained", 64'(out_valid), 64'd0);
    end

    // R5: flag clear yields no output
    present(1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R5", "no output for flag clear", 64'(out_valid), 64'd0);
    check_eq("R5", "beat consumed ready", 64'(in_ready), 64'd1);

    // R7: stall holds output and blocks input
    out_ready = 1'b0;
    present(0, 1'b1);
    @(negedge clk);
    present(4, 1'b1);
    check_vec(0);
    held_sec = out_sec;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R7", "in_ready during stall", 64'(in_ready), 64'd0);
      check_eq("R7", "out_sec held", 64'(out_sec), 64'(held_sec));
      check_eq("R7", "out_valid held", 64'(out_valid), 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(4);
    @(negedge clk);
    check_eq("R7", "empty after drain", 64'(out_valid), 64'd0);

    // R8: back-to-back beats
    present(2, 1'b1);
    @(negedge clk);
    check_vec(2);
    check_eq("R8", "ready while streaming", 64'(in_ready), 64'd1);
    present(7, 1'b1);
    @(negedge clk);
    check_vec(7);
    present(5, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(5);
    @(negedge clk);
    check_eq("R8", "idle after stream", 64'(out_valid), 64'd0);

    finish_run();
  end
endmodule